// File: doc/BRIEF.md
# Iterative Signed/Unsigned Integer Divider

This block divides one 32-bit integer by another over a fixed number of clock cycles, producing one quotient bit per iteration. A single start pulse hands it a dividend, a divisor, a mode bit choosing signed or unsigned arithmetic, and the index of the register that should receive the quotient. The block raises a busy flag while it works. When the quotient is ready it pulses a done strobe, and when the destination index is nonzero it also pulses a writeback enable.

The block never raises an exception. When a division has no defined result, it substitutes a divisor of one and returns the dividend. This covers any divisor of zero, and in signed mode the most-negative dividend divided by minus one. In signed mode the operands are reduced to magnitudes, divided without sign, and the quotient is negated when exactly one operand was negative. The partial remainder lives only inside the iteration datapath. A parameter selects either a restoring or a non-restoring iteration step.

Top module: `int_divider`

## Requirements
- R1: With the mode bit `is_signed` low and a nonzero divisor, `quotient` equals the unsigned floor of dividend divided by divisor.
- R2: With `is_signed` high, operands are two's complement and the quotient rounds toward zero, so its magnitude never exceeds the exact ratio.
- R3: A zero divisor is treated as one in either mode, so `quotient` equals the dividend.
- R4: In signed mode, dividend 0x80000000 over divisor 0xFFFFFFFF treats the divisor as one and gives quotient 0x80000000.
- R5: `done` goes high exactly WIDTH+2 clock edges after the edge that accepts `start` (34 for the default width) and stays high for one cycle only. `quotient` then holds its value until the next completion.
- R6: `busy` is high from the cycle after the accepting edge until `done` rises, and `busy` and `done` are never high together.
- R7: A `start` raised while `busy` is high is ignored. Operands, mode and destination are sampled only at the accepting edge, so later changes on those inputs alter neither the result nor the timing.
- R8: `wb_en` pulses together with `done` only when the destination index sampled at acceptance is nonzero, and `wb_dst` then carries that index. Index 0 gives no writeback.
- R9: A synchronous reset, asserted at any time including mid-division, clears `busy`, `done` and `wb_en`, and the aborted division never completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin a division, taken only while idle |
| is_signed | input | 1 | 1 = two's complement division, 0 = unsigned |
| dividend | input | WIDTH | Numerator |
| divisor | input | WIDTH | Denominator |
| dst | input | DST_W | Destination register index for the quotient |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse, quotient valid |
| quotient | output | WIDTH | Result, held until the next completion |
| wb_en | output | 1 | Writeback pulse, suppressed for destination 0 |
| wb_dst | output | DST_W | Destination index accompanying `wb_en` |

## Verification
The assertions assume that reset is asserted at the first clock edge, and they measure latency only for a start that arrives while the block is idle. The operand checks rely on the checker's own copy of the inputs taken at that same accepting edge. The bench holds reset for several cycles at time zero and drives all inputs on the falling edge. It scrambles operands, mode and destination as soon as a start has been taken, and it fires a stray start in the middle of a division, so that any sampling outside the accepting edge shows up as a wrong quotient or a wrong cycle count.

// File: rtl/div_pkg.sv
package div_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SETUP = 2'd1,
      ST_ITER  = 2'd2,
      ST_FIN   = 2'd3
   } div_state_e;

endpackage

// File: rtl/div_prep.sv
module div_prep #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] num,
   input  logic [WIDTH-1:0] den,
   input  logic             is_signed,
   output logic [WIDTH-1:0] num_mag,
   output logic [WIDTH-1:0] den_mag,
   output logic             neg_res
);
   localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};
   localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
   localparam logic [WIDTH-1:0] ONE      = {{(WIDTH-1){1'b0}}, 1'b1};

   logic             den_zero;
   logic             sgn_ovf;
   logic [WIDTH-1:0] den_fix;
   logic             num_neg;
   logic             den_neg;

   always_comb begin
      den_zero = (den == '0);
      sgn_ovf  = is_signed && (num == MOST_NEG) && (den == ALL_ONES);
      den_fix  = (den_zero || sgn_ovf) ? ONE : den;
      num_neg  = is_signed & num[WIDTH-1];
      den_neg  = is_signed & den_fix[WIDTH-1];
      num_mag  = num_neg ? (~num + ONE) : num;
      den_mag  = den_neg ? (~den_fix + ONE) : den_fix;
      neg_res  = num_neg ^ den_neg;
   end
endmodule

// File: rtl/div_core.sv
module div_core #(
   parameter int WIDTH        = 32,
   parameter bit NONRESTORING = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic             step,
   input  logic [WIDTH-1:0] num_mag,
   input  logic [WIDTH-1:0] den_mag,
   output logic [WIDTH-1:0] quo_mag
);
   localparam int RW = WIDTH + 2;

   logic [RW-1:0]    part_rem;
   logic [WIDTH-1:0] quo_sh;
   logic [WIDTH-1:0] den_r;
   logic [RW-1:0]    shifted;
   logic [RW-1:0]    den_ext;
   logic [RW-1:0]    rem_nxt;
   logic             qbit;

   assign shifted = {part_rem[RW-2:0], quo_sh[WIDTH-1]};
   assign den_ext = {2'b00, den_r};

   generate
      if (NONRESTORING) begin : g_nonrestoring
         always_comb begin
            rem_nxt = part_rem[RW-1] ? (shifted + den_ext) : (shifted - den_ext);
            qbit    = ~rem_nxt[RW-1];
         end
      end else begin : g_restoring
         logic [RW-1:0] trial;
         always_comb begin
            trial   = shifted - den_ext;
            qbit    = ~trial[RW-1];
            rem_nxt = qbit ? trial : shifted;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         part_rem <= '0;
         quo_sh   <= '0;
         den_r    <= '0;
      end else if (load) begin
         part_rem <= '0;
         quo_sh   <= num_mag;
         den_r    <= den_mag;
      end else if (step) begin
         part_rem <= rem_nxt;
         quo_sh   <= {quo_sh[WIDTH-2:0], qbit};
      end
   end

   assign quo_mag = quo_sh;
endmodule

// File: rtl/div_post.sv
module div_post #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] quo_mag,
   input  logic             negate,
   output logic [WIDTH-1:0] quo_out
);
   always_comb begin
      quo_out = negate ? (~quo_mag + {{(WIDTH-1){1'b0}}, 1'b1}) : quo_mag;
   end
endmodule

// File: rtl/int_divider.sv
module int_divider
   import div_pkg::*;
#(
   parameter int WIDTH        = 32,
   parameter int DST_W        = 5,
   parameter bit NONRESTORING = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic             is_signed,
   input  logic [WIDTH-1:0] dividend,
   input  logic [WIDTH-1:0] divisor,
   input  logic [DST_W-1:0] dst,
   output logic             busy,
   output logic             done,
   output logic [WIDTH-1:0] quotient,
   output logic             wb_en,
   output logic [DST_W-1:0] wb_dst
);
   localparam int CNT_W = $clog2(WIDTH);
   localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);

   generate
      if (WIDTH < 4) begin : g_bad_width
         $error("int_divider: WIDTH must be at least 4");
      end
      if ((1 << CNT_W) != WIDTH) begin : g_bad_pow2
         $error("int_divider: WIDTH must be a power of two");
      end
      if (DST_W < 1) begin : g_bad_dst
         $error("int_divider: DST_W must be at least 1");
      end
   endgenerate

   div_state_e       state;
   logic [WIDTH-1:0] num_q;
   logic [WIDTH-1:0] den_q;
   logic             sg_q;
   logic [DST_W-1:0] dst_q;
   logic [CNT_W-1:0] step_cnt;
   logic             neg_r;
   logic [WIDTH-1:0] num_mag;
   logic [WIDTH-1:0] den_mag;
   logic             neg_c;
   logic [WIDTH-1:0] quo_mag;
   logic [WIDTH-1:0] quo_fin;
   logic             accept;
   logic             core_load;
   logic             core_step;

   assign accept    = start && (state == ST_IDLE);
   assign core_load = (state == ST_SETUP);
   assign core_step = (state == ST_ITER);
   assign busy      = (state != ST_IDLE);

   div_prep #(.WIDTH(WIDTH)) u_prep (
      .num       (num_q),
      .den       (den_q),
      .is_signed (sg_q),
      .num_mag   (num_mag),
      .den_mag   (den_mag),
      .neg_res   (neg_c)
   );

   div_core #(.WIDTH(WIDTH), .NONRESTORING(NONRESTORING)) u_core (
      .clk     (clk),
      .rst     (rst),
      .load    (core_load),
      .step    (core_step),
      .num_mag (num_mag),
      .den_mag (den_mag),
      .quo_mag (quo_mag)
   );

   div_post #(.WIDTH(WIDTH)) u_post (
      .quo_mag (quo_mag),
      .negate  (neg_r),
      .quo_out (quo_fin)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state    <= ST_IDLE;
         num_q    <= '0;
         den_q    <= '0;
         sg_q     <= 1'b0;
         dst_q    <= '0;
         step_cnt <= '0;
         neg_r    <= 1'b0;
         done     <= 1'b0;
         wb_en    <= 1'b0;
         wb_dst   <= '0;
         quotient <= '0;
      end else begin
         done  <= 1'b0;
         wb_en <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (accept) begin
                  num_q <= dividend;
                  den_q <= divisor;
                  sg_q  <= is_signed;
                  dst_q <= dst;
                  state <= ST_SETUP;
               end
            end
            ST_SETUP: begin
               neg_r    <= neg_c;
               step_cnt <= '0;
               state    <= ST_ITER;
            end
            ST_ITER: begin
               step_cnt <= step_cnt + 1'b1;
               if (step_cnt == LAST_STEP) begin
                  state <= ST_FIN;
               end
            end
            ST_FIN: begin
               quotient <= quo_fin;
               done     <= 1'b1;
               wb_en    <= (dst_q != '0);
               wb_dst   <= dst_q;
               state    <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/div_chk.sv
module div_chk #(
   parameter int WIDTH = 32,
   parameter int DST_W = 5
) (
   input logic             clk,
   input logic             rst,
   input logic             start,
   input logic             is_signed,
   input logic [WIDTH-1:0] dividend,
   input logic [WIDTH-1:0] divisor,
   input logic [DST_W-1:0] dst,
   input logic             busy,
   input logic             done,
   input logic [WIDTH-1:0] quotient,
   input logic             wb_en,
   input logic [DST_W-1:0] wb_dst
);
   localparam logic [15:0] LAT = 16'(WIDTH + 3);
   localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};

   logic [15:0]      lat_cnt;
   logic [WIDTH-1:0] cap_num;
   logic [WIDTH-1:0] cap_den;
   logic             cap_sg;
   logic [DST_W-1:0] cap_dst;

   always_ff @(posedge clk) begin
      if (rst) begin
         lat_cnt <= '0;
         cap_num <= '0;
         cap_den <= '0;
         cap_sg  <= 1'b0;
         cap_dst <= '0;
      end else if (start && !busy) begin
         lat_cnt <= 16'd1;
         cap_num <= dividend;
         cap_den <= divisor;
         cap_sg  <= is_signed;
         cap_dst <= dst;
      end else if (busy) begin
         lat_cnt <= lat_cnt + 16'd1;
      end
   end

   // R5: one-cycle done, fixed latency (also proves R7 stray starts do not restart)
   a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst) done |=> !done);
   a_r5_latency: assert property (@(posedge clk) disable iff (rst) done |-> (lat_cnt == LAT));
   // R6: busy behaviour
   a_r6_not_both: assert property (@(posedge clk) disable iff (rst) done |-> !busy);
   a_r6_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
      (start && !busy) |=> busy);
   // R3: zero divisor returns dividend
   a_r3_zero_div: assert property (@(posedge clk) disable iff (rst)
      (done && cap_den == '0) |-> (quotient == cap_num));
   // R4: signed overflow case
   a_r4_sgn_ovf: assert property (@(posedge clk) disable iff (rst)
      (done && cap_sg && cap_num == MOST_NEG && cap_den == '1) |-> (quotient == MOST_NEG));
   // R8: writeback gating
   a_r8_wb_with_done: assert property (@(posedge clk) disable iff (rst)
      wb_en |-> (done && wb_dst == cap_dst && wb_dst != '0));
   a_r8_no_wb_zero: assert property (@(posedge clk) disable iff (rst)
      (done && cap_dst == '0) |-> !wb_en);
   // R9: reset clears outputs
   a_r9_reset_clear: assert property (@(posedge clk) rst |=> (!busy && !done && !wb_en));
endmodule

bind int_divider div_chk #(.WIDTH(WIDTH), .DST_W(DST_W)) u_div_chk (
   .clk       (clk),
   .rst       (rst),
   .start     (start),
   .is_signed (is_signed),
   .dividend  (dividend),
   .divisor   (divisor),
   .dst       (dst),
   .busy      (busy),
   .done      (done),
   .quotient  (quotient),
   .wb_en     (wb_en),
   .wb_dst    (wb_dst)
);

// File: tb/int_divider_tb.sv
module int_divider_tb_top;
   localparam int LAT = 34;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic        is_signed = 1'b0;
   logic [31:0] dividend = '0;
   logic [31:0] divisor = '0;
   logic [4:0]  dst = '0;
   logic        busy;
   logic        done;
   logic [31:0] quotient;
   logic        wb_en;
   logic [4:0]  wb_dst;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   int_divider dut_i (
      .clk       (clk),
      .rst       (rst),
      .start     (start),
      .is_signed (is_signed),
      .dividend  (dividend),
      .divisor   (divisor),
      .dst       (dst),
      .busy      (busy),
      .done      (done),
      .quotient  (quotient),
      .wb_en     (wb_en),
      .wb_dst    (wb_dst)
   );

   function automatic logic [31:0] ref_quo(logic [31:0] a, logic [31:0] b, logic sg);
      int sa;
      int sb;
      if (!sg) begin
         if (b == 32'd0) return a;
         return a / b;
      end
      sa = $signed(a);
      sb = $signed(b);
      if (sb == 0 || (a == 32'h8000_0000 && sb == -1)) sb = 1;
      return 32'(sa / sb);
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic run_div(input logic [31:0] a, input logic [31:0] b, input logic sg,
                          input logic [4:0] d, input bit stray, input string req);
      logic [31:0] exp;
      int lat;
      bit got;
      exp = ref_quo(a, b, sg);
      @(negedge clk);
      start = 1'b1; dividend = a; divisor = b; is_signed = sg; dst = d;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      dividend = $urandom; divisor = $urandom; is_signed = ~sg; dst = 5'($urandom);
      lat = 0; got = 1'b0;
      while (!got && lat < 100) begin
         if (stray && lat == 5) begin
            start = 1'b1; dividend = $urandom; divisor = 32'd3; is_signed = ~sg;
         end
         if (stray && lat == 6) start = 1'b0;
         if (lat < LAT - 1) chk(busy == 1'b1, "R6", "busy during run", 32'(busy), 32'd1);
         @(posedge clk);
         lat++;
         @(negedge clk);
         if (done) got = 1'b1;
      end
      chk(lat == LAT, "R5", "latency", 32'(lat), 32'(LAT));
      chk(quotient == exp, req, "quotient", quotient, exp);
      chk(busy == 1'b0, "R6", "busy with done", 32'(busy), 32'd0);
      chk(wb_en == (d != 5'd0), "R8", "wb_en", 32'(wb_en), 32'(d != 5'd0));
      if (d != 5'd0) chk(wb_dst == d, "R8", "wb_dst", 32'(wb_dst), 32'(d));
      @(posedge clk);
      @(negedge clk);
      chk(done == 1'b0, "R5", "done pulse width", 32'(done), 32'd0);
      chk(quotient == exp, "R5", "quotient held", quotient, exp);
   endtask

   initial begin
      #(200000 * 10);
      if (!finished) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(!busy && !done && !wb_en, "R9", "state after reset", {29'd0, busy, done, wb_en}, 32'd0);
      rst = 1'b0;

      // directed corner cases
      run_div(32'd100, 32'd7, 1'b0, 5'd3, 1'b0, "R1");
      run_div(32'hFFFF_FFFF, 32'd1, 1'b0, 5'd31, 1'b0, "R1");
      run_div(32'h1234_5678, 32'h1234_5679, 1'b0, 5'd1, 1'b0, "R1");
      run_div(32'hFFFF_FFF9, 32'd2, 1'b1, 5'd4, 1'b0, "R2");   // -7/2 = -3
      run_div(32'd7, 32'hFFFF_FFFE, 1'b1, 5'd5, 1'b0, "R2");   // 7/-2 = -3
      run_div(32'hFFFF_FFF9, 32'hFFFF_FFFE, 1'b1, 5'd6, 1'b0, "R2");
      run_div(32'h8000_0000, 32'd2, 1'b1, 5'd7, 1'b0, "R2");
      run_div(32'hDEAD_BEEF, 32'd0, 1'b0, 5'd8, 1'b0, "R3");
      run_div(32'h8765_4321, 32'd0, 1'b1, 5'd9, 1'b0, "R3");
      run_div(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 5'd10, 1'b0, "R4");
      run_div(32'h8000_0000, 32'hFFFF_FFFF, 1'b0, 5'd11, 1'b0, "R1");
      run_div(32'd1000, 32'd10, 1'b0, 5'd0, 1'b0, "R8");
      run_div(32'd999, 32'd4, 1'b1, 5'd12, 1'b1, "R7");

      // R9: reset mid-division aborts it
      @(negedge clk);
      start = 1'b1; dividend = 32'd50; divisor = 32'd5; is_signed = 1'b0; dst = 5'd2;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      repeat (10) @(posedge clk);
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      chk(!busy && !done && !wb_en, "R9", "mid-run reset", {29'd0, busy, done, wb_en}, 32'd0);
      begin
         bit seen = 1'b0;
         for (int i = 0; i < 40; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (done || busy) seen = 1'b1;
         end
         chk(!seen, "R9", "aborted run stays silent", 32'(seen), 32'd0);
      end

      // constrained random
      for (int n = 0; n < 80; n++) begin
         logic [31:0] a;
         logic [31:0] b;
         logic        sg;
         a  = $urandom;
         sg = 1'(n % 2);
         case ($urandom % 4)
            0: b = $urandom % 16;
            1: b = $urandom % 65536;
            2: b = -($urandom % 16);
            default: b = $urandom;
         endcase
         run_div(a, b, sg, 5'($urandom), (n % 7) == 3, sg ? "R2" : "R1");
      end

      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule